// File: doc/BRIEF.md
# Audio Sample Recorder into a Paged Serial Flash

The block sits between a sampling front end and a serial flash memory during recording. Each time the front end presents a 10-bit conversion result with the record enable held, the block shrinks it to an 8-bit code. It subtracts a fixed floor value of 0x1D5, then keeps only the low eight bits of the difference. It then sends that code over an SPI master into the next byte slot of the flash's 528-byte on-chip buffer.

When the last buffer slot has been filled, the block waits for the flash's ready/busy line to show idle. It then commands a program of the buffer into the next free page of the main array. The byte and page positions survive the release of record enable, so a later session appends after the audio already stored. When the eraser signals that memory is blank, the block restarts at the first byte of the first page and acknowledges that flag. Once every page has been written, further samples are dropped until record enable is released. A sample that arrives while the block is still working on an earlier one sets a sticky overrun flag.

Top module: `audio_page_recorder`

## Requirements
- R1: The stored code is (sample − 0x1D5) modulo 256. Examples: 0x1D5 gives 0x00, 0x1D4 gives 0xFF, 0x3FF gives 0x2A and 0x000 gives 0x2B.
- R2: A buffer write is one chip-select-low frame of 40 bits, most significant bit first, with the data sampled on the rising SCK edge (mode 0). The frame is the byte 0x84, then 14 zero bits, then the 10-bit byte position, then the 8-bit code. SCK toggles only while chip select is low, and it is low when chip select falls.
- R3: Accepted samples occupy byte positions 0, 1, 2 … up to the buffer size minus one, in arrival order.
- R4: After the last byte position of a buffer has been written, exactly one 32-bit frame follows. It is the byte 0x88, then 2 zero bits, then the 12-bit page number, then 10 zero bits. Page numbers rise by one for each buffer.
- R5: The page program frame does not start while flash_ready is low. It starts once flash_ready is high.
- R6: The byte and page positions are kept while rec_en is low, so the next accepted sample continues at the following position.
- R7: An accepted sample that sees mem_empty high, with no full-memory lockout pending, is written at byte 0 of page 0. mem_full then clears, and empty_ack pulses high for exactly one clock.
- R8: mem_full goes high once the last page has been programmed. While it is high, samples produce no SPI traffic. After a sample has been dropped as full, this also holds with mem_empty high, until rec_en goes low.
- R9: A sample that arrives while a frame is being sent, or while a page program is waiting, is dropped and sets overrun. overrun stays high until reset.
- R10: Samples with rec_en low produce no SPI traffic and do not move the write position.
- R11: After reset, spi_cs_n is high, spi_sck is low, and mem_full, overrun and empty_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_en | input | 1 | Record enable (button held) |
| smp_valid | input | 1 | One-cycle strobe: new conversion result |
| smp_data | input | ADC_W | Raw conversion result |
| mem_empty | input | 1 | Memory has been erased by the eraser |
| empty_ack | output | 1 | One-cycle pulse: erased flag consumed |
| mem_full | output | 1 | Every page holds recorded data |
| overrun | output | 1 | Sticky: a sample was lost to a busy link |
| flash_ready | input | 1 | Flash ready/busy line, high when idle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The bound checker watches these rules on every cycle:
- SCK moves only inside a chip-select window and starts low.
- A page program never begins against a busy flash.
- The overrun flag sets whenever a sample lands inside a frame, and it never clears.
- The erase acknowledge is a single-cycle pulse.
- The full flag drops only on an erase restart.

Only the bench scenarios can show the content of each frame: the reduced codes, the byte positions and the page numbers. The same holds for appending across sessions, the lockout of a full memory until release, and the restart after an erase. These are checked by decoding the serial stream against a position model kept in the bench.

// File: rtl/rec_pkg.sv
package rec_pkg;
   localparam logic [7:0] OP_BUF_WRITE = 8'h84;
   localparam logic [7:0] OP_PAGE_PROG = 8'h88;
   localparam int CMD_ADDR_W = 24;
   localparam int OP_W       = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WR   = 2'd1,
      ST_WAIT = 2'd2,
      ST_PG   = 2'd3
   } rec_state_t;
endpackage

// File: rtl/rec_reduce.sv
module rec_reduce #(
   parameter int ADC_W  = 10,
   parameter int SMP_W  = 8,
   parameter int OFFSET = 'h1D5
) (
   input  logic [ADC_W-1:0] raw,
   output logic [SMP_W-1:0] code
);
   logic [ADC_W-1:0] diff;
   assign diff = raw - ADC_W'(OFFSET);

   generate
      if (ADC_W > SMP_W) begin : g_trunc
         assign code = diff[SMP_W-1:0];
      end else begin : g_extend
         assign code = SMP_W'(diff);
      end
   endgenerate
endmodule

// File: rtl/rec_addr.sv
module rec_addr #(
   parameter int BUF_BYTES = 528,
   parameter int PAGES     = 4096,
   parameter int BYTE_AW   = 10,
   parameter int PAGE_AW   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               step_byte,
   input  logic               step_page,
   output logic [BYTE_AW-1:0] byte_pos,
   output logic [PAGE_AW:0]   page_pos,
   output logic               last_byte,
   output logic               full
);
   localparam logic [BYTE_AW-1:0] LAST_B = BYTE_AW'(BUF_BYTES - 1);
   localparam logic [PAGE_AW:0]   PG_END = (PAGE_AW+1)'(PAGES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_pos <= '0;
         page_pos <= '0;
      end else if (clr) begin
         byte_pos <= '0;
         page_pos <= '0;
      end else if (step_page) begin
         byte_pos <= '0;
         page_pos <= page_pos + 1'b1;
      end else if (step_byte) begin
         byte_pos <= byte_pos + 1'b1;
      end
   end

   assign last_byte = (byte_pos == LAST_B);
   assign full      = (page_pos == PG_END);
endmodule

// File: rtl/rec_spi_tx.sv
module rec_spi_tx #(
   parameter int MAXB = 40,
   parameter int HALF = 2,
   localparam int NB_W  = $clog2(MAXB + 1),
   localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NB_W-1:0] nbits,
   input  logic [MAXB-1:0] frame,
   output logic            busy,
   output logic            done,
   output logic            sck,
   output logic            mosi,
   output logic            cs_n
);
   logic [MAXB-1:0]  sh;
   logic [NB_W-1:0]  left;
   logic [DIV_W-1:0] div;
   logic             active;
   logic             tick;

   assign tick = (div == DIV_W'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         left   <= '0;
         div    <= '0;
         active <= 1'b0;
         sck    <= 1'b0;
         cs_n   <= 1'b1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               cs_n   <= 1'b0;
               sh     <= frame;
               left   <= nbits;
               div    <= '0;
               sck    <= 1'b0;
            end
         end else if (tick) begin
            div <= '0;
            if (!sck) begin
               sck <= 1'b1;
            end else begin
               sck  <= 1'b0;
               sh   <= sh << 1;
               left <= left - 1'b1;
               if (left == NB_W'(1)) begin
                  active <= 1'b0;
                  cs_n   <= 1'b1;
                  done   <= 1'b1;
               end
            end
         end else begin
            div <= div + 1'b1;
         end
      end
   end

   assign busy = active;
   assign mosi = active & sh[MAXB-1];
endmodule

// File: rtl/audio_page_recorder.sv
module audio_page_recorder #(
   parameter int ADC_W     = 10,
   parameter int SMP_W     = 8,
   parameter int OFFSET    = 'h1D5,
   parameter int BUF_BYTES = 528,
   parameter int PAGES     = 4096,
   parameter int BYTE_AW   = 10,
   parameter int PAGE_AW   = 12,
   parameter int SCK_HALF  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rec_en,
   input  logic             smp_valid,
   input  logic [ADC_W-1:0] smp_data,
   input  logic             mem_empty,
   output logic             empty_ack,
   output logic             mem_full,
   output logic             overrun,
   input  logic             flash_ready,
   output logic             spi_cs_n,
   output logic             spi_sck,
   output logic             spi_mosi
);
   import rec_pkg::*;

   localparam int FR_W    = OP_W + CMD_ADDR_W + SMP_W;
   localparam int PG_BITS = OP_W + CMD_ADDR_W;
   localparam int NB_W    = $clog2(FR_W + 1);
   localparam int WR_PAD  = CMD_ADDR_W - BYTE_AW;
   localparam int PG_DC   = CMD_ADDR_W - 2 - PAGE_AW;

   generate
      if (BUF_BYTES < 1 || BUF_BYTES > (1 << BYTE_AW)) begin : g_bad_buf
         $error("BUF_BYTES does not fit BYTE_AW");
      end
      if (PAGES < 1 || PAGES > (1 << PAGE_AW)) begin : g_bad_pages
         $error("PAGES does not fit PAGE_AW");
      end
      if (PG_DC < 0 || WR_PAD < 0) begin : g_bad_addr
         $error("address fields exceed the command address width");
      end
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
   endgenerate

   rec_state_t state, nxt;
   logic lock_q, ack_q, ovr_q;
   logic take, restart;
   logic wr_start, pg_start, clr, ack_c, step_b, step_p, lock_set;
   logic [BYTE_AW-1:0] byte_pos, pos_sel;
   logic [PAGE_AW:0]   page_pos;
   logic last_byte, full;
   logic [SMP_W-1:0] code;
   logic [FR_W-1:0]  wr_frame, pg_frame, tx_frame;
   logic [NB_W-1:0]  tx_bits;
   logic tx_busy, tx_done;

   rec_reduce #(.ADC_W(ADC_W), .SMP_W(SMP_W), .OFFSET(OFFSET)) u_reduce (
      .raw  (smp_data),
      .code (code)
   );

   rec_addr #(.BUF_BYTES(BUF_BYTES), .PAGES(PAGES),
              .BYTE_AW(BYTE_AW), .PAGE_AW(PAGE_AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step_byte (step_b),
      .step_page (step_p),
      .byte_pos  (byte_pos),
      .page_pos  (page_pos),
      .last_byte (last_byte),
      .full      (full)
   );

   assign take    = smp_valid & rec_en;
   assign restart = mem_empty & ~lock_q;

   always_comb begin
      nxt      = state;
      wr_start = 1'b0;
      pg_start = 1'b0;
      clr      = 1'b0;
      ack_c    = 1'b0;
      step_b   = 1'b0;
      step_p   = 1'b0;
      lock_set = 1'b0;
      pos_sel  = byte_pos;
      case (state)
         ST_IDLE: begin
            if (take) begin
               if (restart) begin
                  clr      = 1'b1;
                  ack_c    = 1'b1;
                  pos_sel  = '0;
                  wr_start = 1'b1;
                  nxt      = ST_WR;
               end else if (full || lock_q) begin
                  lock_set = 1'b1;
               end else begin
                  wr_start = 1'b1;
                  nxt      = ST_WR;
               end
            end
         end
         ST_WR: begin
            if (tx_done) begin
               if (last_byte) begin
                  nxt = ST_WAIT;
               end else begin
                  step_b = 1'b1;
                  nxt    = ST_IDLE;
               end
            end
         end
         ST_WAIT: begin
            if (flash_ready && !tx_busy) begin
               pg_start = 1'b1;
               nxt      = ST_PG;
            end
         end
         ST_PG: begin
            if (tx_done) begin
               step_p = 1'b1;
               nxt    = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign wr_frame = {OP_BUF_WRITE, {WR_PAD{1'b0}}, pos_sel, code};
   assign pg_frame = {OP_PAGE_PROG, 2'b00, page_pos[PAGE_AW-1:0],
                      {PG_DC{1'b0}}, {SMP_W{1'b0}}};
   assign tx_frame = wr_start ? wr_frame : pg_frame;
   assign tx_bits  = wr_start ? NB_W'(FR_W) : NB_W'(PG_BITS);

   rec_spi_tx #(.MAXB(FR_W), .HALF(SCK_HALF)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_start | pg_start),
      .nbits (tx_bits),
      .frame (tx_frame),
      .busy  (tx_busy),
      .done  (tx_done),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .cs_n  (spi_cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         lock_q <= 1'b0;
         ack_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         state <= nxt;
         ack_q <= ack_c;
         if (!rec_en)       lock_q <= 1'b0;
         else if (lock_set) lock_q <= 1'b1;
         if (take && state != ST_IDLE) ovr_q <= 1'b1;
      end
   end

   assign empty_ack = ack_q;
   assign overrun   = ovr_q;
   assign mem_full  = full;
endmodule

// File: rtl/rec_checker.sv
module rec_checker (
   input logic clk,
   input logic rst_n,
   input logic rec_en,
   input logic smp_valid,
   input logic mem_empty,
   input logic flash_ready,
   input logic pg_start,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic mem_full,
   input logic overrun,
   input logic empty_ack
);
   // R2: the serial clock moves only inside a chip-select window
   assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n);

   // R2: each frame opens with the clock low (mode 0)
   assert_frame_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> !spi_sck);

   // R5: page program launched only against an idle flash
   assert_prog_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pg_start |-> flash_ready);

   // R9: a sample landing inside a frame raises overrun
   assert_sample_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_en && smp_valid && !spi_cs_n) |=> overrun);

   // R9: overrun never clears once set
   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7: the erased-flag acknowledge is a single-cycle pulse
   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty_ack |=> !empty_ack);

   // R8: full drops only through an erase restart
   assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_full && !(rec_en && smp_valid && mem_empty)) |=> mem_full);
endmodule

bind audio_page_recorder rec_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rec_en      (rec_en),
   .smp_valid   (smp_valid),
   .mem_empty   (mem_empty),
   .flash_ready (flash_ready),
   .pg_start    (pg_start),
   .spi_cs_n    (spi_cs_n),
   .spi_sck     (spi_sck),
   .mem_full    (mem_full),
   .overrun     (overrun),
   .empty_ack   (empty_ack)
);

// File: tb/sim_audio_page_recorder.sv
`timescale 1ns/1ps
module sim_audio_page_recorder;
   localparam int BUF = 4;
   localparam int PGS = 3;
   localparam int SP  = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rec_en = 1'b0, smp_valid = 1'b0, mem_empty = 1'b0, flash_ready = 1'b1;
   logic [9:0] smp_data = '0;
   logic empty_ack, mem_full, overrun, cs_n, sck, mosi;

   always #5 clk = ~clk;

   audio_page_recorder #(.BUF_BYTES(BUF), .PAGES(PGS), .SCK_HALF(2)) u0 (
      .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .smp_valid(smp_valid),
      .smp_data(smp_data), .mem_empty(mem_empty), .empty_ack(empty_ack),
      .mem_full(mem_full), .overrun(overrun), .flash_ready(flash_ready),
      .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   // serial frame capture
   logic [63:0] rx_sh = '0;
   int rx_bits = 0;
   logic [63:0] rx_f [0:63];
   int rx_l [0:63];
   int rx_n = 0, rx_rd = 0;
   always @(posedge sck or posedge cs_n) begin
      if (cs_n === 1'b1) begin
         if (rx_bits != 0 && rx_n < 64) begin
            rx_f[rx_n] = rx_sh;
            rx_l[rx_n] = rx_bits;
            rx_n++;
         end
         rx_bits = 0;
         rx_sh = '0;
      end else begin
         rx_sh = {rx_sh[62:0], mosi};
         rx_bits++;
      end
   end

   int ack_cnt = 0;
   always @(posedge clk) if (rst_n && empty_ack === 1'b1) ack_cnt++;

   // expected frames and position model
   logic [63:0] ex_f [0:63];
   int ex_l [0:63];
   int ex_n = 0, ex_rd = 0;
   int m_byte = 0, m_page = 0, m_ack = 0;
   bit m_lock = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] red(input logic [9:0] a);
      int d;
      d = ((int'(a) - 469) % 256 + 256) % 256;
      return 8'(d);
   endfunction

   task automatic push(input logic [63:0] f, input int l);
      ex_f[ex_n] = f;
      ex_l[ex_n] = l;
      ex_n++;
   endtask

   task automatic model_write(input logic [9:0] a);
      push({24'h0, 8'h84, 14'h0, 10'(m_byte), red(a)}, 40);
      if (m_byte == BUF - 1) begin
         push({32'h0, 8'h88, 2'b00, 12'(m_page), 10'h0}, 32);
         m_page++;
         m_byte = 0;
      end else begin
         m_byte++;
      end
   endtask

   task automatic pulse(input logic [9:0] a);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = a;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic sample(input logic [9:0] a);
      if (rec_en) begin
         if (mem_empty && !m_lock) begin
            m_byte = 0;
            m_page = 0;
            m_ack++;
            model_write(a);
         end else if (m_page == PGS) begin
            m_lock = 1;
         end else begin
            model_write(a);
         end
      end
      pulse(a);
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_frames(input string tag);
      chk(rx_n - rx_rd == ex_n - ex_rd, tag, 64'(rx_n - rx_rd), 64'(ex_n - ex_rd));
      while (rx_rd < rx_n && ex_rd < ex_n) begin
         chk(rx_f[rx_rd] == ex_f[ex_rd] && rx_l[rx_rd] == ex_l[ex_rd], tag,
             rx_f[rx_rd], ex_f[ex_rd]);
         rx_rd++;
         ex_rd++;
      end
      rx_rd = rx_n;
      ex_rd = ex_n;
   endtask

   task automatic smp_chk(input logic [9:0] a, input string tag);
      sample(a);
      waitc(SP);
      check_frames(tag);
   endtask

   task automatic set_rec(input logic v);
      @(negedge clk);
      rec_en = v;
      if (!v) m_lock = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      waitc(4);
      // R11: reset state
      chk(cs_n === 1'b1 && sck === 1'b0, "R11 spi idle", {62'h0, cs_n, sck}, 64'h2);
      chk(mem_full === 1'b0 && overrun === 1'b0 && empty_ack === 1'b0, "R11 flags",
          {61'h0, mem_full, overrun, empty_ack}, 64'h0);
      rst_n = 1'b1;
      waitc(4);

      // R7: erased memory, restart at 0/0 with one acknowledge
      mem_empty = 1'b1;
      set_rec(1'b1);
      sample(10'h1D5);
      @(negedge clk);
      mem_empty = 1'b0;
      waitc(SP);
      check_frames("R7 restart frame (R1 code 0x00, R2 format)");
      chk(ack_cnt == m_ack, "R7 ack count", 64'(ack_cnt), 64'(m_ack));

      // R1, R3, R4: reduction sweep filling page 0
      smp_chk(10'h1D4, "R1 code 0xFF at position 1 (R3)");
      smp_chk(10'h3FF, "R1 code 0x2A at position 2 (R3)");
      smp_chk(10'h000, "R4 last byte then program page 0");

      // R10: record enable low ignores samples
      set_rec(1'b0);
      smp_chk(10'h200, "R10 sample ignored");
      set_rec(1'b1);
      for (int i = 0; i < 2; i++) smp_chk(10'(10'h1E0 + i * 37), "R3 page 1 positions");

      // R6: release and resume appends
      set_rec(1'b0);
      smp_chk(10'h100, "R10 ignored between sessions");
      set_rec(1'b1);
      smp_chk(10'h2F0, "R6 append at next position");

      // R5: program held while flash busy
      @(negedge clk);
      flash_ready = 1'b0;
      sample(10'h255);
      waitc(SP);
      chk(rx_n - rx_rd == 1 && cs_n === 1'b1, "R5 no program while busy",
          64'(rx_n - rx_rd), 64'd1);
      flash_ready = 1'b1;
      waitc(SP);
      check_frames("R5 program after ready (R4 page 1)");

      // R9: sample during a transfer is dropped, overrun sticks
      smp_chk(10'h1F0, "R3 page 2 first byte");
      sample(10'h222);
      waitc(20);
      pulse(10'h333);
      waitc(SP);
      check_frames("R9 second sample dropped");
      chk(overrun === 1'b1, "R9 overrun set", {63'h0, overrun}, 64'h1);

      // R8: fill last page, then discard
      smp_chk(10'h1D6, "R3 page 2 byte 2");
      smp_chk(10'h1D7, "R4 program page 2");
      chk(mem_full === 1'b1, "R8 full after last page", {63'h0, mem_full}, 64'h1);
      smp_chk(10'h300, "R8 discard while full");
      @(negedge clk);
      mem_empty = 1'b1;
      smp_chk(10'h301, "R8 locked until release despite erase");
      chk(mem_full === 1'b1, "R8 still full while locked", {63'h0, mem_full}, 64'h1);

      // R7: after release, erased flag restarts recording
      set_rec(1'b0);
      waitc(5);
      set_rec(1'b1);
      sample(10'h2AA);
      @(negedge clk);
      mem_empty = 1'b0;
      waitc(SP);
      check_frames("R7 restart after erase");
      chk(mem_full === 1'b0, "R7 full cleared", {63'h0, mem_full}, 64'h0);
      chk(ack_cnt == m_ack, "R7 second ack", 64'(ack_cnt), 64'(m_ack));
      chk(overrun === 1'b1, "R9 overrun still sticky", {63'h0, overrun}, 64'h1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule